// File: doc/BRIEF.md
# Core Register File with Special Registers

This block is the register file of a small processor core. Nine architectural entries are selected by a 4-bit index. One entry is a hardwired zero. One holds the program counter. One holds the stack pointer. One is a read-only copy of the core's identifier. Five are general data registers. Two read ports are combinational. A single write port updates the selected entry on the rising clock edge.

The stack lives in the core's local data memory. It starts at the top address and grows downward. Two strobes move the stack pointer. The push strobe pre-decrements it, and the address it presents is the new, lower value. The pop strobe post-increments it, and the address it presents is the current value. The program counter and the stack pointer each have their own output, so fetch and stack logic can read them without using a read port. The identifier comes in on an input pin, so every core in a multi-core array can be given its own value.

Top module: `core_regfile`

## Requirements
- R1: Index 0 always reads as zero on both read ports, and a write to index 0 changes no entry.
- R2: The index encoding is 1 = program counter, 2 = stack pointer, and 4 through 8 = data registers A through E. A write to one of these indices is visible on both read ports from the next cycle on. `pc_out` and `sp_out` always show entries 1 and 2.
- R3: Index 3 reads the value on `core_id`. A write to index 3 changes no entry.
- R4: Indices 9 through 15 read as zero, and a write to any of them changes no entry.
- R5: While `rst_n` is low, the stack pointer is MEM_DEPTH-1 (127 by default) and the program counter and data registers A through E are zero.
- R6: When `push` is high and `pop` is low, `stack_addr` equals the stack pointer minus one in that same cycle, and the stack pointer takes that value at the next edge.
- R7: When `pop` is high and `push` is low, `stack_addr` equals the current stack pointer, and the stack pointer increases by one at the next edge. When neither strobe is high, `stack_addr` equals the stack pointer.
- R8: A port write to index 2 in the same cycle as a push or a pop takes priority. The stack pointer becomes the written data.
- R9: There is no write-to-read bypass. A read of the index being written, in the cycle of the write, returns the old value.
- R10: When `push` and `pop` are both high, the push is carried out and the pop is ignored.
- R11: The stack pointer has no bounds protection. A push at 0 wraps it to all ones, and a pop at all ones wraps it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_id | input | DW | Identifier returned at index 3 |
| rd_idx_a | input | 4 | Read port A index |
| rd_data_a | output | DW | Read port A data |
| rd_idx_b | input | 4 | Read port B index |
| rd_data_b | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | DW | Write data |
| push | input | 1 | Pre-decrement stack pointer |
| pop | input | 1 | Post-increment stack pointer |
| stack_addr | output | DW | Data memory address for the current push or pop |
| sp_out | output | DW | Current stack pointer |
| pc_out | output | DW | Current program counter |

## Verification
The hardest situation to reach is three requests aimed at the stack pointer in one cycle: a port write to index 2, a push and a pop, together with a read of index 2. Under uniform random stimulus this lines up too rarely. The random phase therefore biases the write index toward 2 and raises the strobe rates, so the collisions of R8 and R10 occur often. Directed steps drive the stack pointer to 0 and to all ones to exercise the wrap of R11.

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int DW        = 16,
  parameter int MEM_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] core_id,
  input  logic [3:0]    rd_idx_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [3:0]    rd_idx_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] stack_addr,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] pc_out
);
  localparam logic [DW-1:0] SP_TOP = DW'(MEM_DEPTH - 1);
  localparam int NGP = 5;

  logic [DW-1:0] pc_q, sp_q;
  logic [DW-1:0] gp_q [NGP];
  logic          sp_wr;

  function automatic logic [DW-1:0] sel(input logic [3:0] i);
    case (i)
      4'd1:    return pc_q;
      4'd2:    return sp_q;
      4'd3:    return core_id;
      4'd4:    return gp_q[0];
      4'd5:    return gp_q[1];
      4'd6:    return gp_q[2];
      4'd7:    return gp_q[3];
      4'd8:    return gp_q[4];
      default: return '0;
    endcase
  endfunction

  assign rd_data_a  = sel(rd_idx_a);
  assign rd_data_b  = sel(rd_idx_b);
  assign sp_out     = sp_q;
  assign pc_out     = pc_q;
  assign stack_addr = push ? sp_q - 1'b1 : sp_q;
  assign sp_wr      = wr_en && wr_idx == 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= SP_TOP;
      for (int k = 0; k < NGP; k++) gp_q[k] <= '0;
    end else begin
      if (wr_en && wr_idx == 4'd1) pc_q <= wr_data;
      if (sp_wr)     sp_q <= wr_data;
      else if (push) sp_q <= sp_q - 1'b1;
      else if (pop)  sp_q <= sp_q + 1'b1;
      for (int k = 0; k < NGP; k++)
        if (wr_en && wr_idx == 4'(k + 4)) gp_q[k] <= wr_data;
    end
  end

  a_r1_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_a == 4'd0 |-> rd_data_a == '0);
  a_r4_high_idx_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_b > 4'd8 |-> rd_data_b == '0);
  a_r3_spid_ro: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_a == 4'd3 |-> rd_data_a == core_id);
  a_r6_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    push && !sp_wr |=> sp_out == $past(sp_out) - 1'b1);
  a_r7_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !sp_wr |=> sp_out == $past(sp_out) + 1'b1);
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> sp_out == $past(wr_data));
  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == 4'd1) |=> $stable(pc_out));
endmodule

// File: tb/tb_core_regfile.sv
module tb_core_regfile;
  localparam int DW = 16;
  localparam logic [DW-1:0] ID = 16'h00A5;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] core_id = ID;
  logic [3:0] rd_idx_a = 0, rd_idx_b = 0, wr_idx = 0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = 0, stack_addr, sp_out, pc_out;
  logic wr_en = 0, push = 0, pop = 0;

  int checks = 0, fails = 0;
  logic [DW-1:0] m_pc, m_sp;
  logic [DW-1:0] m_gp [5];

  core_regfile dut (.*);

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(input logic [3:0] i);
    if (i == 1) return m_pc;
    if (i == 2) return m_sp;
    if (i == 3) return ID;
    if (i >= 4 && i <= 8) return m_gp[i-4];
    return '0;
  endfunction

  function automatic string tag_of(input logic [3:0] i);
    if (i == 0) return "R1";
    if (i == 3) return "R3";
    if (i > 8) return "R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_sp = 16'd127;
    for (int k = 0; k < 5; k++) m_gp[k] = 0;
  endtask

  task automatic model_step();
    if (wr_en && wr_idx == 1) m_pc = wr_data;
    if (wr_en && wr_idx >= 4 && wr_idx <= 8) m_gp[wr_idx-4] = wr_data;
    if (wr_en && wr_idx == 2) m_sp = wr_data;
    else if (push) m_sp = m_sp - 1;
    else if (pop) m_sp = m_sp + 1;
  endtask

  task automatic check_all();
    string st;
    check(tag_of(rd_idx_a), rd_data_a, exp_rd(rd_idx_a));
    check(tag_of(rd_idx_b), rd_data_b, exp_rd(rd_idx_b));
    check("R2 sp_out", sp_out, m_sp);
    check("R2 pc_out", pc_out, m_pc);
    if (push && pop) st = "R10";
    else if (push) st = "R6";
    else st = "R7";
    check(st, stack_addr, push ? m_sp - 1 : m_sp);
    if (wr_en && wr_idx == rd_idx_a)
      check("R9", rd_data_a, exp_rd(rd_idx_a));
  endtask

  task automatic cyc();
    #1; check_all();
    @(posedge clk); model_step();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk); @(negedge clk);
    check("R5 sp", sp_out, 16'd127);
    check("R5 pc", pc_out, 16'd0);
    rd_idx_a = 4; rd_idx_b = 8; #1;
    check("R5 gpA", rd_data_a, 0);
    check("R5 gpE", rd_data_b, 0);
    rst_n = 1;
    @(negedge clk);

    wr_en = 1; wr_idx = 0; wr_data = 16'hBEEF; rd_idx_a = 0; cyc();
    wr_idx = 3; wr_data = 16'h1111; rd_idx_a = 3; cyc();
    wr_idx = 12; wr_data = 16'h2222; rd_idx_a = 12; cyc();
    wr_en = 0; rd_idx_a = 0; rd_idx_b = 3; cyc();
    check("R4 pc untouched", pc_out, 0);

    wr_en = 1; wr_idx = 2; wr_data = 16'h0040; push = 1; pop = 1; cyc();
    check("R8", sp_out, 16'h0040);
    wr_en = 0; push = 1; pop = 1; cyc();
    check("R10", sp_out, 16'h003F);
    push = 0; pop = 0;

    wr_en = 1; wr_idx = 2; wr_data = 16'h0000; cyc();
    wr_en = 0; push = 1; cyc();
    check("R11 wrap down", sp_out, 16'hFFFF);
    push = 0; pop = 1; cyc();
    check("R11 wrap up", sp_out, 16'h0000);
    pop = 0;

    wr_en = 1; wr_idx = 5; wr_data = 16'h5A5A; rd_idx_a = 5; cyc();
    wr_en = 0; cyc();
    check("R2 next-cycle read", rd_data_a, 16'h5A5A);

    for (int n = 0; n < 3000; n++) begin
      wr_en    = ($urandom % 4) != 0;
      wr_idx   = ($urandom % 3 == 0) ? 4'd2 : 4'($urandom % 16);
      wr_data  = 16'($urandom);
      push     = ($urandom % 3) == 0;
      pop      = ($urandom % 3) == 0;
      rd_idx_a = ($urandom % 2) ? wr_idx : 4'($urandom % 16);
      rd_idx_b = 4'($urandom % 16);
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule